// File: doc/BRIEF.md
# Multiple-Register Transfer Sequencer

This block drives a load/store pipe through a block transfer of several registers. A single start pulse hands it a register list with one bit for each register, a base word address and a direction. From the next cycle on, it produces one memory beat per cycle. Each beat carries one or two register indices and the word address of its first register. It keeps the arithmetic pipe stalled until the final beat has gone out.

Registers are moved in ascending index order to ascending word addresses, starting at the base. A beat carries two registers only when its address starts a doubleword, which means bit 0 of the word address is zero. A base that starts in the middle of a doubleword therefore opens with a single-register beat, and pairing resumes at the next doubleword boundary. All accesses are assumed to hit. Each beat therefore takes exactly one cycle, and the sequencer has no back-pressure input.

Top module: `mreg_xfer_seq`

## Requirements
- R1: After reset, and whenever the block is idle, `stall_o` is 0, `done_o` is 0 and `lane_vld_o` is 2'b00.
- R2: A `start_i` seen at a clock edge while idle captures the list, base and direction. The first beat (or, for an empty list, the completion cycle) is presented in the very next cycle.
- R3: Every register whose bit is set in the list appears exactly once, in ascending index order. When both lanes are valid (`lane_vld_o` = 2'b11), `lane1_idx_o` is the next listed register after `lane0_idx_o`. `lane_vld_o` = 2'b01 marks a single-register beat.
- R4: `beat_word_o` is the base word address plus the position of the lane 0 register in the list. Lane 1, when valid, occupies the following word.
- R5: When bit 0 of the base word address is 0, every beat pairs two registers except possibly the last. N listed registers take ceil(N/2) beats.
- R6: When bit 0 of the base word address is 1, the first beat carries one register and later beats pair from the doubleword boundary. N ≥ 1 registers take 1 + floor(N/2) beats. A pair never starts at an odd word address.
- R7: `stall_o` is 1 in every cycle from the one after the accepted start through the final beat, and 0 in the cycle after it.
- R8: `done_o` is 1 for exactly one cycle, coinciding with the final beat.
- R9: An empty list completes in one cycle: `stall_o` and `done_o` are both 1 and no lane is valid.
- R10: `start_i` while a transfer is in progress is ignored. The running beats are unchanged, and no transfer follows once it ends.
- R11: `load_o` presents the captured direction (1 = load, 0 = store) in every cycle of the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a transfer (accepted only while idle) |
| reg_list_i | input | NREG | One bit per register to transfer |
| base_word_i | input | AW | Base word address |
| load_i | input | 1 | Direction: 1 = load, 0 = store |
| stall_o | output | 1 | Hold the arithmetic execute stage |
| lane_vld_o | output | 2 | Beat valid mask: bit 0 lane 0, bit 1 lane 1 |
| lane0_idx_o | output | IW | Register index carried by lane 0 |
| lane1_idx_o | output | IW | Register index carried by lane 1 (0 when unused) |
| beat_word_o | output | AW | Word address of the lane 0 register |
| load_o | output | 1 | Direction of the running transfer |
| done_o | output | 1 | Final cycle of the transfer |

## Verification
The bench builds the block with its defaults: a 16-entry list and a 30-bit word address. This makes the full list reachable, including the 8-beat aligned case and the 9-beat unaligned case, with both settings of the base's doubleword bit. A behavioural model expands each list into a queue of expected beats. The design is compared against that queue on every cycle, so the pairing decisions, the address sequence and the stall release cycle are checked for directed lists and a sweep of random lists. Beat counts are also checked against the closed formulas for aligned and unaligned bases, and a start pulse is injected during transfers to confirm that it is ignored.

// File: rtl/mxs_pkg.sv
package mxs_pkg;

    // Number of register lanes a single memory beat can carry.
    localparam int unsigned LANES = 2;

    // Transfer direction as presented on load_i / load_o.
    typedef enum logic {
        DIR_STORE = 1'b0,
        DIR_LOAD  = 1'b1
    } xfer_dir_e;

endpackage

// File: rtl/mxs_first_set.sv
// Finds the lowest set bit of a vector.
module mxs_first_set #(
    parameter int unsigned N  = 16,
    parameter int unsigned IW = 4
) (
    input  logic [N-1:0]  vec_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);

    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        // Scan downward so the lowest set bit is the last one written.
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/mxs_beat_pick.sv
// Chooses the registers carried by one beat and the list left after it.
module mxs_beat_pick
    import mxs_pkg::*;
#(
    parameter int unsigned NREG = 16,
    parameter int unsigned IW   = 4
) (
    input  logic [NREG-1:0]  rem_i,
    input  logic             pair_ok_i,
    output logic [LANES-1:0] vld_o,
    output logic [IW-1:0]    idx0_o,
    output logic [IW-1:0]    idx1_o,
    output logic [NREG-1:0]  rem_nxt_o,
    output logic [1:0]       nwords_o
);

    logic            found0, found1;
    logic [IW-1:0]   first0, first1;
    logic [NREG-1:0] after0, after1;
    logic            take1;

    mxs_first_set #(.N(NREG), .IW(IW)) u_lane0 (
        .vec_i   (rem_i),
        .found_o (found0),
        .idx_o   (first0)
    );

    assign after0 = found0 ? (rem_i & ~(NREG'(1) << first0)) : rem_i;

    mxs_first_set #(.N(NREG), .IW(IW)) u_lane1 (
        .vec_i   (after0),
        .found_o (found1),
        .idx_o   (first1)
    );

    assign after1 = after0 & ~(NREG'(1) << first1);

    always_comb begin
        take1     = pair_ok_i && found0 && found1;
        vld_o     = {take1, found0};
        idx0_o    = first0;
        idx1_o    = take1 ? first1 : '0;
        rem_nxt_o = take1 ? after1 : after0;
        nwords_o  = take1 ? 2'd2 : (found0 ? 2'd1 : 2'd0);
    end

endmodule

// File: rtl/mreg_xfer_seq.sv
module mreg_xfer_seq
    import mxs_pkg::*;
#(
    parameter int unsigned NREG = 16,
    parameter int unsigned AW   = 30,
    localparam int unsigned IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [NREG-1:0]  reg_list_i,
    input  logic [AW-1:0]    base_word_i,
    input  logic             load_i,
    output logic             stall_o,
    output logic [LANES-1:0] lane_vld_o,
    output logic [IW-1:0]    lane0_idx_o,
    output logic [IW-1:0]    lane1_idx_o,
    output logic [AW-1:0]    beat_word_o,
    output logic             load_o,
    output logic             done_o
);

    typedef struct packed {
        logic            busy;
        logic [NREG-1:0] rem;
        logic [AW-1:0]   waddr;
        xfer_dir_e       dir;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic [LANES-1:0] pick_vld;
    logic [IW-1:0]    pick_idx0, pick_idx1;
    logic [NREG-1:0]  pick_rem;
    logic [1:0]       pick_nwords;

    // A pair may only start on an even word (doubleword boundary).
    mxs_beat_pick #(.NREG(NREG), .IW(IW)) u_pick (
        .rem_i     (st_q.rem),
        .pair_ok_i (~st_q.waddr[0]),
        .vld_o     (pick_vld),
        .idx0_o    (pick_idx0),
        .idx1_o    (pick_idx1),
        .rem_nxt_o (pick_rem),
        .nwords_o  (pick_nwords)
    );

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy  = 1'b1;
                st_d.rem   = reg_list_i;
                st_d.waddr = base_word_i;
                st_d.dir   = xfer_dir_e'(load_i);
            end
        end else begin
            st_d.rem   = pick_rem;
            st_d.waddr = st_q.waddr + AW'(pick_nwords);
            if (pick_rem == '0) begin
                st_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stall_o     = st_q.busy;
    assign lane_vld_o  = st_q.busy ? pick_vld : '0;
    assign lane0_idx_o = pick_idx0;
    assign lane1_idx_o = pick_idx1;
    assign beat_word_o = st_q.waddr;
    assign load_o      = (st_q.dir == DIR_LOAD);
    assign done_o      = st_q.busy && (pick_rem == '0);

    // ---------------------------------------------------------------
    // Assertions
    // ---------------------------------------------------------------
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !stall_o |-> (lane_vld_o == '0 && !done_o));

    assert_pair_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lane_vld_o[1] |-> (lane_vld_o[0] && lane1_idx_o > lane0_idx_o));

    assert_next_beat_higher_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_vld_o[0] && !done_o) |=>
            (lane0_idx_o > ($past(lane_vld_o[1]) ? $past(lane1_idx_o) : $past(lane0_idx_o))));

    assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_vld_o[0] && !done_o) |=>
            (beat_word_o == $past(beat_word_o) + ($past(lane_vld_o[1]) ? AW'(2) : AW'(1))));

    assert_pair_on_even_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lane_vld_o[1] |-> !beat_word_o[0]);

    assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_o && !done_o) |=> stall_o);

    assert_release_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!stall_o && !done_o));

    assert_dir_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_o && !done_o) |=> $stable(load_o));

endmodule

// File: tb/mreg_xfer_seq_test.sv
module mreg_xfer_seq_test;

    localparam int NREG = 16;
    localparam int AW   = 30;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            start_i;
    logic [NREG-1:0] reg_list_i;
    logic [AW-1:0]   base_word_i;
    logic            load_i;
    logic            stall_o;
    logic [1:0]      lane_vld_o;
    logic [3:0]      lane0_idx_o, lane1_idx_o;
    logic [AW-1:0]   beat_word_o;
    logic            load_o;
    logic            done_o;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #10 clk = ~clk;   // 50 MHz

    mreg_xfer_seq uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .reg_list_i(reg_list_i),
        .base_word_i(base_word_i), .load_i(load_i), .stall_o(stall_o),
        .lane_vld_o(lane_vld_o), .lane0_idx_o(lane0_idx_o), .lane1_idx_o(lane1_idx_o),
        .beat_word_o(beat_word_o), .load_o(load_o), .done_o(done_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Run one transfer against a queue-based model; optionally poke start mid-run.
    task automatic run_xfer(input logic [NREG-1:0] list, input logic [AW-1:0] base,
                            input logic ld, input bit poke);
        int regs[$];
        int e_l0[$], e_l1[$], e_vm[$];
        longint e_ad[$];
        logic [AW-1:0] a;
        int n, nb, ncyc, seen, formula;
        int i;
        foreach (list[k]) if (list[k]) regs.push_back(k);
        regs.sort();
        n = regs.size();
        a = base;
        i = 0;
        while (i < n) begin
            if (!a[0] && (i + 1 < n)) begin
                e_l0.push_back(regs[i]); e_l1.push_back(regs[i+1]);
                e_vm.push_back(3); e_ad.push_back(longint'(a));
                i += 2; a += 2;
            end else begin
                e_l0.push_back(regs[i]); e_l1.push_back(0);
                e_vm.push_back(1); e_ad.push_back(longint'(a));
                i += 1; a += 1;
            end
        end
        nb = e_vm.size();
        if (n == 0) formula = 0;
        else if (!base[0]) formula = (n + 1) / 2;      // R5
        else formula = 1 + n / 2;                     // R6
        check(nb == formula, base[0] ? "R6" : "R5", "model beat count", nb, formula);

        @(negedge clk);
        start_i = 1'b1; reg_list_i = list; base_word_i = base; load_i = ld;
        ncyc = (nb == 0) ? 1 : nb;
        seen = 0;
        for (int c = 0; c < ncyc; c++) begin
            @(negedge clk);
            if (c == 0) begin
                if (poke) begin
                    reg_list_i = ~list; base_word_i = base + 5; load_i = ~ld;   // R10
                end else start_i = 1'b0;
            end
            if (c == ncyc - 1) start_i = 1'b0;
            check(stall_o == 1'b1, "R7", "stall during transfer", stall_o, 1);
            check(done_o == (c == ncyc - 1), "R8", "done timing", done_o, (c == ncyc - 1));
            check(load_o == ld, "R11", "direction", load_o, ld);
            if (lane_vld_o != 2'b00) seen++;
            if (nb == 0) begin
                check(lane_vld_o == 2'b00, "R9", "empty list lanes", lane_vld_o, 0);
            end else begin
                check(lane_vld_o == e_vm[c], "R2", "beat mask", lane_vld_o, e_vm[c]);
                check(lane0_idx_o == e_l0[c], "R3", "lane0 index", lane0_idx_o, e_l0[c]);
                if (e_vm[c] == 3)
                    check(lane1_idx_o == e_l1[c], "R3", "lane1 index", lane1_idx_o, e_l1[c]);
                check(longint'(beat_word_o) == e_ad[c], "R4", "beat address",
                      beat_word_o, e_ad[c]);
            end
        end
        check(seen == formula, base[0] ? "R6" : "R5", "observed beats", seen, formula);
        @(negedge clk);
        check(stall_o == 1'b0, "R7", "stall release", stall_o, 0);
        check(done_o == 1'b0 && lane_vld_o == 2'b00, "R1", "idle outputs",
              {done_o, lane_vld_o}, 0);
        if (poke) begin
            @(negedge clk);
            check(stall_o == 1'b0, "R10", "no transfer after ignored start", stall_o, 0);
        end
    endtask

    initial begin
        rst_n = 1'b0; start_i = 1'b0; reg_list_i = '0; base_word_i = '0; load_i = 1'b0;
        repeat (3) @(negedge clk);
        check(stall_o == 1'b0, "R1", "reset stall", stall_o, 0);
        check(done_o == 1'b0, "R1", "reset done", done_o, 0);
        check(lane_vld_o == 2'b00, "R1", "reset lanes", lane_vld_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(stall_o == 1'b0, "R1", "idle after reset", stall_o, 0);

        run_xfer(16'h0000, 30'h100, 1'b1, 1'b0);   // R9 empty, aligned
        run_xfer(16'h0000, 30'h101, 1'b0, 1'b0);   // R9 empty, unaligned
        run_xfer(16'hFFFF, 30'h200, 1'b1, 1'b0);   // R5 full: 8 beats
        run_xfer(16'hFFFF, 30'h201, 1'b0, 1'b0);   // R6 full: 9 beats
        run_xfer(16'h0008, 30'h301, 1'b1, 1'b0);   // R6 single register
        run_xfer(16'h8001, 30'h301, 1'b1, 1'b0);   // R6 two registers, 2 beats
        run_xfer(16'h8001, 30'h300, 1'b0, 1'b0);   // R5 two registers, 1 beat
        run_xfer(16'h0007, 30'h3FFF_FFFF, 1'b1, 1'b0); // R4 address wrap
        run_xfer(16'h0F0F, 30'h040, 1'b1, 1'b1);   // R10 poke while busy
        run_xfer(16'h0000, 30'h041, 1'b0, 1'b1);   // R10 poke on empty list

        for (int t = 0; t < 300; t++) begin
            logic [NREG-1:0] l;
            logic [AW-1:0]   b;
            l = NREG'($urandom);
            if (t % 7 == 0) l = l & NREG'($urandom);
            b = AW'($urandom);
            run_xfer(l, b, 1'($urandom), (t % 5 == 0));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule